// File: doc/BRIEF.md
# Dual-Clock FIFO with Status Flags

This block is an 18-bit first-in first-out buffer whose write side and read side each run on their own clock with their own enable. A word is stored on every write-clock rising edge that sees the write enable high and room in the buffer. A word is taken out on every read-clock rising edge that sees the read enable high and data in the buffer. The two clocks may be the same net or fully unrelated. The depth is a parameter (64, 256, 512, 1024, 2048 or 4096 words, 1024 by default).

Each status flag belongs to one clock domain. The write side reports full and more-than-half-full. The read side reports empty and marks each delivered word with a one-cycle valid strobe. The pointers cross between domains as Gray code through two-flop synchronizers. A retransmit input on the read side rewinds reading to the first word stored since reset, so a short burst can be replayed when the buffer is used on its own.

Reset is synchronous and active high, and it is sampled by both clocks. It has to stay high for several cycles of the slower clock.

Top module: `dual_clock_fifo`

## Requirements
- R1: Words leave the read port in exactly the order in which they were accepted at the write port, with no word lost or repeated.
- R2: A write is accepted on a `wclk` rising edge when `wr_en` is 1 and `wr_full` is 0. A read is accepted on an `rclk` rising edge when `rd_en` is 1, `rd_empty` is 0 and `rd_rt` is 0. Back-to-back enables move one word per edge.
- R3: `rd_empty` changes only on `rclk` edges. It goes to 1 once every stored word has been read, and it returns to 0 a few `rclk` cycles after a write.
- R4: `wr_full` changes only on `wclk` edges. It goes to 1 as soon as DEPTH words are stored and unread, and it clears a few `wclk` cycles after a read.
- R5: A read accepted at an `rclk` edge drives `rd_data` with that word and sets `rd_valid` to 1 for the following cycle only. The first word can therefore be obtained one `rclk` cycle after `rd_empty` falls.
- R6: Once the flags have settled, `wr_half` is 1 when more than DEPTH/2 words are stored and 0 when DEPTH/2 or fewer are stored. It is always 1 while `wr_full` is 1.
- R7: A write attempted while `wr_full` is 1 is ignored. No word is stored and the write pointer does not move.
- R8: A read attempted while `rd_empty` is 1 is ignored. `rd_valid` stays 0 and the read pointer does not move.
- R9: An `rclk` edge with `rd_rt` at 1 rewinds the read pointer to the first word written since reset, provided fewer than DEPTH words have been written since reset. A read requested on the same edge is not performed.
- R10: While reset is applied and just after it, `rd_empty` is 1 and `wr_full`, `wr_half` and `rd_valid` are 0, and earlier contents are discarded.
- R11: With unrelated clock frequencies and writes and reads running at the same time, R1 still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| wr_en | input | 1 | Write request |
| wr_data | input | DW (18) | Word to store |
| wr_full | output | 1 | Buffer full (write domain) |
| wr_half | output | 1 | More than half full (write domain) |
| rd_en | input | 1 | Read request |
| rd_rt | input | 1 | Retransmit: rewind reading to the first word since reset |
| rd_data | output | DW (18) | Word read out |
| rd_valid | output | 1 | `rd_data` holds a freshly read word |
| rd_empty | output | 1 | Buffer empty (read domain) |

## Verification
The main function is driven in three patterns. The first is a table of fill and drain phases that steps occupancy across one word, exactly half, half plus one, and full. This separates an off-by-one in the half-full compare from one in the full compare. The second is a forced write burst against a full buffer and a forced read burst against an empty one, and it shows whether the guard conditions really block the pointers. The third runs writes and reads concurrently on unrelated clocks, which exposes errors in the Gray crossing that ordered phases would hide. Separate directed runs cover the first-word latency, a retransmit that collides with a read request, and a reset in the middle of traffic.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DCF_DATA_W    = 18;
  localparam int DCF_DEPTH_DEF = 1024;

  // Depths the block is built for
  function automatic bit dcf_depth_legal(input int d);
    return (d == 64) || (d == 256) || (d == 512) ||
           (d == 1024) || (d == 2048) || (d == 4096);
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 18,
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port, suits block RAM
  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wside.sv
module dcf_wside #(
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  output logic          accept,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full_q,
  output logic          half_q
);
  localparam logic [AW:0] HALF = (AW+1)'(1) << (AW-1);

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] from_gray(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] wbin, wbin_nx, wgray_nx, rbin_s, occ_nx, rfull_pat;

  assign accept    = wr_en & ~full_q;
  assign wbin_nx   = wbin + {{AW{1'b0}}, accept};
  assign wgray_nx  = to_gray(wbin_nx);
  assign rbin_s    = from_gray(rgray_s);
  assign occ_nx    = wbin_nx - rbin_s;
  assign rfull_pat = {~rgray_s[AW:AW-1], rgray_s[AW-2:0]};
  assign waddr     = wbin[AW-1:0];

  always_ff @(posedge wclk) begin
    if (rst) begin
      wbin   <= '0;
      wgray  <= '0;
      full_q <= 1'b0;
      half_q <= 1'b0;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wgray_nx;
      full_q <= (wgray_nx == rfull_pat);
      half_q <= (occ_nx > HALF);
    end
  end

  // R7
  full_hold_chk: assert property (@(posedge wclk) disable iff (rst)
    full_q |=> $stable(wbin));

  // R6
  full_half_chk: assert property (@(posedge wclk) disable iff (rst)
    full_q |-> half_q);
endmodule

// File: rtl/dcf_rside.sv
module dcf_rside #(
  parameter int AW = 10
) (
  input  logic          rclk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          rt,
  input  logic [AW:0]   wgray_s,
  output logic          accept,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          empty_q,
  output logic          valid_q
);
  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [AW:0] rbin, rbin_nx, rgray_nx;

  assign accept   = rd_en & ~empty_q & ~rt;
  assign rbin_nx  = rt ? '0 : rbin + {{AW{1'b0}}, accept};
  assign rgray_nx = to_gray(rbin_nx);
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge rclk) begin
    if (rst) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_q <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      rbin    <= rbin_nx;
      rgray   <= rgray_nx;
      empty_q <= (rgray_nx == wgray_s);
      valid_q <= accept;
    end
  end

  // R8
  empty_hold_chk: assert property (@(posedge rclk) disable iff (rst)
    (empty_q && !rt) |=> $stable(rbin));

  // R5
  valid_src_chk: assert property (@(posedge rclk) disable iff (rst)
    valid_q |-> $past(rd_en && !empty_q && !rt));

  // R9
  rewind_chk: assert property (@(posedge rclk) disable iff (rst)
    rt |=> (rbin == '0) && !valid_q);
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DW    = dcf_pkg::DCF_DATA_W,
  parameter int DEPTH = dcf_pkg::DCF_DEPTH_DEF
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  output logic          wr_half,
  input  logic          rd_en,
  input  logic          rd_rt,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_empty
);
  localparam int AW = $clog2(DEPTH);

  generate
    if (!dcf_pkg::dcf_depth_legal(DEPTH)) begin : g_bad_depth
      initial $error("dual_clock_fifo: unsupported DEPTH %0d", DEPTH);
    end
  endgenerate

  logic          w_acc, r_acc;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;

  dcf_wside #(.AW(AW)) u_wside (
    .wclk(wclk), .rst(rst), .wr_en(wr_en), .rgray_s(rgray_s),
    .accept(w_acc), .waddr(waddr), .wgray(wgray),
    .full_q(wr_full), .half_q(wr_half)
  );

  dcf_rside #(.AW(AW)) u_rside (
    .rclk(rclk), .rst(rst), .rd_en(rd_en), .rt(rd_rt), .wgray_s(wgray_s),
    .accept(r_acc), .raddr(raddr), .rgray(rgray),
    .empty_q(rd_empty), .valid_q(rd_valid)
  );

  dcf_sync #(.W(AW+1)) u_w2r (
    .clk(rclk), .rst(rst), .d(wgray), .q(wgray_s)
  );

  dcf_sync #(.W(AW+1)) u_r2w (
    .clk(wclk), .rst(rst), .d(rgray), .q(rgray_s)
  );

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(w_acc), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .re(r_acc), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: tb/test_dual_clock_fifo.sv
`timescale 1ns/1ps
module test_dual_clock_fifo;
  localparam int DW    = 18;
  localparam int DEPTH = 1024;
  localparam int NROW  = 8;

  // Table: writes, reads, forced, expected empty/half/full after settling
  localparam int VW  [NROW] = '{1, 511, 1, 0,  512, 5, 0,    0};
  localparam int VR  [NROW] = '{0, 0,   0, 1,  0,   0, 1024, 3};
  localparam bit VF  [NROW] = '{0, 0,   0, 0,  0,   1, 0,    1};
  localparam bit VE  [NROW] = '{0, 0,   0, 0,  0,   0, 1,    1};
  localparam bit VH  [NROW] = '{0, 0,   1, 0,  1,   1, 0,    0};
  localparam bit VFU [NROW] = '{0, 0,   0, 0,  1,   1, 0,    0};

  logic wclk = 0, rclk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0, rd_rt = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_full, wr_half, rd_valid, rd_empty;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0, wseq = 1, cyc = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] hist[$];

  always #4    wclk = ~wclk;
  always #4.85 rclk = ~rclk;

  dual_clock_fifo #(.DW(DW), .DEPTH(DEPTH)) i_dual_clock_fifo (
    .wclk(wclk), .rclk(rclk), .rst(rst),
    .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full), .wr_half(wr_half),
    .rd_en(rd_en), .rd_rt(rd_rt), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_empty(rd_empty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R1 R11: every delivered word must match the model order
  always @(negedge rclk) begin
    if (!rst && rd_valid) begin
      if (q.size() == 0) chk(0, "R8", "word delivered from empty", int'(rd_data), -1);
      else begin
        logic [DW-1:0] e;
        e = q.pop_front();
        chk(rd_data == e, "R1", "read order", int'(rd_data), int'(e));
      end
    end
  end

  task automatic do_reset();
    rst = 1; wr_en = 0; rd_en = 0; rd_rt = 0;
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
    q.delete(); hist.delete();
    rst = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  task automatic do_writes(input int n, input bit frc);
    int done = 0;
    while (done < n) begin
      @(negedge wclk);
      if (frc || !wr_full) begin
        wr_en = 1; wr_data = DW'(wseq);
        if (!wr_full) begin q.push_back(DW'(wseq)); hist.push_back(DW'(wseq)); end
        wseq++; done++;
      end else wr_en = 0;
    end
    @(negedge wclk); wr_en = 0;
  endtask

  task automatic do_reads(input int n, input bit frc);
    int done = 0;
    while (done < n) begin
      @(negedge rclk);
      if (frc || !rd_empty) begin rd_en = 1; done++; end
      else rd_en = 0;
    end
    @(negedge rclk); rd_en = 0;
    @(negedge rclk);
  endtask

  initial begin
    forever begin
      @(posedge wclk);
      cyc++;
      if (cyc == 150000) begin
        chk(0, "watchdog", "run did not finish", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    // R10 reset state
    do_reset();
    @(negedge rclk);
    chk(rd_empty == 1, "R10", "empty after reset", rd_empty, 1);
    chk(rd_valid == 0, "R10", "valid after reset", rd_valid, 0);
    chk(wr_full == 0, "R10", "full after reset", wr_full, 0);
    chk(wr_half == 0, "R10", "half after reset", wr_half, 0);

    // R5 first word one cycle after empty falls
    do_writes(1, 0);
    while (rd_empty) @(negedge rclk);
    rd_en = 1;
    @(negedge rclk);
    chk(rd_valid == 1, "R5", "valid after first read", rd_valid, 1);
    rd_en = 0;
    @(negedge rclk);
    chk(rd_valid == 0, "R5", "valid one cycle only", rd_valid, 0);
    settle();

    // Table walk: R2 R3 R4 R6 R7 R8
    for (int i = 0; i < NROW; i++) begin
      if (VW[i] > 0) do_writes(VW[i], VF[i]);
      if (VR[i] > 0) do_reads(VR[i], VF[i]);
      settle();
      chk(rd_empty == VE[i], "R3", $sformatf("empty row %0d", i), rd_empty, VE[i]);
      chk(wr_half == VH[i], "R6", $sformatf("half row %0d", i), wr_half, VH[i]);
      chk(wr_full == VFU[i], "R4", $sformatf("full row %0d", i), wr_full, VFU[i]);
      chk(q.size() == (VE[i] ? 0 : q.size()), "R2", $sformatf("model row %0d", i), q.size(), 0);
    end
    // R8: pointers untouched by forced reads, next word still in order
    do_writes(1, 0);
    settle();
    do_reads(1, 0);
    settle();
    chk(q.size() == 0, "R8", "word after empty reads", q.size(), 0);

    // R9 retransmit colliding with a read request
    do_reset();
    do_writes(10, 0);
    settle();
    do_reads(4, 0);
    @(negedge rclk);
    rd_rt = 1; rd_en = 1;
    @(negedge rclk);
    rd_rt = 0; rd_en = 0;
    chk(rd_valid == 0, "R9", "no read on rewind edge", rd_valid, 0);
    q = hist;
    settle();
    chk(rd_empty == 0, "R9", "data after rewind", rd_empty, 0);
    do_reads(10, 0);
    settle();
    chk(q.size() == 0, "R9", "replayed words", q.size(), 0);
    chk(rd_empty == 1, "R9", "empty after replay", rd_empty, 1);

    // R10 reset in the middle of traffic
    do_writes(600, 0);
    settle();
    do_reset();
    settle();
    chk(rd_empty == 1, "R10", "empty after mid reset", rd_empty, 1);
    chk(wr_half == 0, "R10", "half after mid reset", wr_half, 0);

    // R11 concurrent traffic on unrelated clocks
    fork
      do_writes(1500, 0);
      do_reads(1500, 0);
    join
    settle();
    chk(q.size() == 0, "R11", "words left in model", q.size(), 0);
    chk(rd_empty == 1, "R11", "empty after stream", rd_empty, 1);
    chk(wr_full == 0, "R11", "full after stream", wr_full, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule